// File: doc/BRIEF.md
# Single-precision to 8-bit float narrowing converter

This block narrows one IEEE binary32 value into an 8-bit floating-point code. Each transfer selects one of two target layouts: a 4-exponent/3-mantissa layout with bias 7 and no infinity, or a 5-exponent/2-mantissa layout with bias 15 and IEEE-style infinities. The result comes with an overflow flag and an underflow flag. Normal results, subnormal results, signed zeros, infinities and NaNs each follow the rules below.

Rounding is round-to-nearest-even unless the transfer asks for stochastic rounding. In that mode a caller-supplied random word is added to the fraction bits that are about to be dropped, and a carry out of that sum rounds the magnitude up. The block is a two-stage pipeline. A valid/ready handshake runs on both sides, and one stall signal freezes both stages.

Top module: `fp8_narrow`

## Requirements
- R1: A value accepted in cycle n (in_valid and in_ready both high) appears with out_valid high in cycle n+2 when out_ready is held high, and out_valid is low in cycle n+1 when the pipeline was empty before.
- R2: While out_valid is high and out_ready is low, out_code, out_ovf and out_unf hold and in_ready is low. No accepted value is lost or duplicated.
- R3: Code layout is sign in bit 7. With in_fmt=0 the exponent is bits 6:3 (bias 7) and the mantissa is bits 2:0. With in_fmt=1 the exponent is bits 6:2 (bias 15) and the mantissa is bits 1:0. Exact inputs convert exactly, e.g. 1.0 gives 0x38 and 0x3C.
- R4: With in_stoch=0 the magnitude rounds to nearest with ties to even, including a carry from the mantissa into the exponent.
- R5: Values below the target's normal range become subnormal codes or zero. Binary32 subnormal inputs become a signed zero. out_unf is high exactly when a nonzero finite input gives a zero magnitude.
- R6: In format 0 a rounded magnitude above 448 gives sign|0x7E with out_ovf high, whatever in_sat is. 448 itself, and the tie at 464, give 0x7E with no flag.
- R7: In format 1 a rounded magnitude above 57344 sets out_ovf. The code is sign|0x7C (infinity) when in_sat=0 and sign|0x7B when in_sat=1.
- R8: Infinite inputs give sign|0x7C in format 1 (even with in_sat=1) and sign|0x7F in format 0. No flag is raised.
- R9: NaN inputs give the canonical NaN with the input sign: sign|0x7F in format 0 and sign|0x7E in format 1. No flag is raised.
- R10: A zero input gives a zero code with the same sign and no flag.
- R11: With in_stoch=1, the low k bits of in_rand (k = number of dropped fraction bits, at most 25) are added to the dropped bits, and a carry rounds up. Exact values never change, and bits of in_rand above k have no effect.
- R12: out_ovf and out_unf are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Block can take a value this cycle |
| in_data | input | 32 | Binary32 source value |
| in_fmt | input | 1 | Target layout: 0 = 4/3 split, 1 = 5/2 split |
| in_sat | input | 1 | Clamp overflow to the finite maximum (format 1 only) |
| in_stoch | input | 1 | Select stochastic rounding |
| in_rand | input | RND_W (25) | Random bits for stochastic rounding |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_code | output | 8 | 8-bit float result |
| out_ovf | output | 1 | Rounded magnitude exceeded the target maximum |
| out_unf | output | 1 | Nonzero input rounded to zero |

## Verification
Five properties are checked on every valid output cycle: results hold under backpressure, the overflow code for each format, the zero magnitude that goes with underflow, and that the two flags never rise together. Whether a code is numerically right cannot be seen from the outputs alone. Ties to even, subnormal placement, the exact 448 and 57344 boundaries, the handling of special inputs and the stochastic carry are shown only by the bench's directed scenarios, which compare against values worked out by hand. The scenarios also show the exact two-cycle latency and that out-of-window random bits are ignored.

// File: rtl/fp8_narrow_pkg.sv
package fp8_narrow_pkg;

   localparam int SRC_FRAC_W = 23;
   localparam int SRC_BIAS   = 127;
   localparam int MAX_SHIFT  = 25;
   localparam int NUM_FMT    = 2;

   typedef enum logic {
      FMT_E4M3 = 1'b0,
      FMT_E5M2 = 1'b1
   } fmt_e;

   typedef enum logic [2:0] {
      CLS_ZERO,
      CLS_TINY,
      CLS_NORM,
      CLS_INF,
      CLS_NAN
   } cls_e;

   typedef struct packed {
      logic        sign;
      cls_e        cls;
      logic [7:0]  exp8;
      logic [23:0] sig24;
   } unp_t;

   function automatic int fmt_exp_w(input int idx);
      return (idx == 0) ? 4 : 5;
   endfunction

   function automatic int fmt_man_w(input int idx);
      return (idx == 0) ? 3 : 2;
   endfunction

endpackage

// File: rtl/fp8_narrow_unpack.sv
module fp8_narrow_unpack
   import fp8_narrow_pkg::*;
(
   input  logic [31:0] f32,
   output unp_t        unp
);
   logic [7:0]  e;
   logic [22:0] f;

   assign e = f32[30:23];
   assign f = f32[22:0];

   always_comb begin
      unp.sign  = f32[31];
      unp.exp8  = e;
      unp.sig24 = {(e != 8'd0), f};
      if (e == 8'hFF)      unp.cls = (f == '0) ? CLS_INF : CLS_NAN;
      else if (e == 8'd0)  unp.cls = (f == '0) ? CLS_ZERO : CLS_TINY;
      else                 unp.cls = CLS_NORM;
   end
endmodule

// File: rtl/fp8_narrow_round.sv
module fp8_narrow_round
   import fp8_narrow_pkg::*;
#(
   parameter int EXP_W    = 4,
   parameter int MAN_W    = 3,
   parameter bit IEEE_SP  = 1'b0,
   parameter bit STOCH_EN = 1'b1,
   parameter int RND_W    = 25
) (
   input  unp_t             unp,
   input  logic             sat,
   input  logic             stoch,
   input  logic [RND_W-1:0] rnd,
   output logic [7:0]       code,
   output logic             ovf,
   output logic             unf
);
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam int EMIN  = 1 - BIAS;
   localparam int DROP0 = SRC_FRAC_W - MAN_W;
   localparam int INFC  = ((1 << EXP_W) - 1) << MAN_W;
   localparam int NANC  = IEEE_SP ? (INFC | (1 << (MAN_W - 1))) : ((1 << (EXP_W + MAN_W)) - 1);
   localparam int MAXC  = IEEE_SP ? ((((1 << EXP_W) - 2) << MAN_W) | ((1 << MAN_W) - 1))
                                  : ((1 << (EXP_W + MAN_W)) - 2);
   localparam logic signed [9:0] EMIN_S  = 10'(EMIN);
   localparam logic signed [9:0] BIAS_S  = 10'(BIAS);
   localparam logic signed [9:0] DROP_S  = 10'(DROP0);
   localparam logic signed [9:0] SHMAX_S = 10'(MAX_SHIFT);

   if (1 + EXP_W + MAN_W != 8) begin : g_bad_width
      $error("fp8_narrow_round: format must total 8 bits");
   end
   if (RND_W < MAX_SHIFT) begin : g_bad_rnd
      $error("fp8_narrow_round: RND_W must cover the widest dropped field");
   end

   logic signed [9:0] unb, ebe, defc, sh10;
   logic [4:0]        sh;
   logic [25:0]       sigx, mask, disc, kept, half;
   logic              rne_up, sr_up, up;
   logic [11:0]       mag;

   always_comb begin
      unb = $signed({2'b00, unp.exp8}) - 10'sd127;
      if (unb < EMIN_S) begin
         defc = EMIN_S - unb;
         ebe  = 10'sd1;
      end else begin
         defc = '0;
         ebe  = unb + BIAS_S;
      end
      sh10 = DROP_S + defc;
      sh   = (sh10 > SHMAX_S) ? 5'(MAX_SHIFT) : sh10[4:0];
      sigx = {2'b00, unp.sig24};
      mask = (26'd1 << sh) - 26'd1;
      disc = sigx & mask;
      kept = sigx >> sh;
      half = 26'd1 << (sh - 5'd1);
      rne_up = (disc > half) || ((disc == half) && kept[0]);
   end

   if (STOCH_EN) begin : g_stoch
      logic [25:0] rmask;
      logic [26:0] sum;
      always_comb begin
         rmask = {1'b0, rnd[MAX_SHIFT-1:0]} & mask;
         sum   = {1'b0, disc} + {1'b0, rmask};
         sr_up = sum > {1'b0, mask};
      end
   end else begin : g_rne_only
      assign sr_up = 1'b0;
   end

   always_comb begin
      up  = (STOCH_EN && stoch) ? sr_up : rne_up;
      mag = (12'(ebe - 10'sd1) << MAN_W) + 12'(kept) + {11'd0, up};
      code = {unp.sign, 7'd0};
      ovf  = 1'b0;
      unf  = 1'b0;
      unique case (unp.cls)
         CLS_ZERO: ;
         CLS_TINY: unf = 1'b1;
         CLS_NAN:  code = {unp.sign, 7'(NANC)};
         CLS_INF:  code = {unp.sign, IEEE_SP ? 7'(INFC) : 7'(NANC)};
         default: begin
            if (mag > 12'(MAXC)) begin
               ovf  = 1'b1;
               code = {unp.sign, (IEEE_SP && !sat) ? 7'(INFC) : 7'(MAXC)};
            end else begin
               code = {unp.sign, mag[6:0]};
               unf  = (mag == 12'd0);
            end
         end
      endcase
   end
endmodule

// File: rtl/fp8_narrow.sv
module fp8_narrow
   import fp8_narrow_pkg::*;
#(
   parameter int RND_W    = 25,
   parameter bit STOCH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [31:0]      in_data,
   input  logic             in_fmt,
   input  logic             in_sat,
   input  logic             in_stoch,
   input  logic [RND_W-1:0] in_rand,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_code,
   output logic             out_ovf,
   output logic             out_unf
);
   if (RND_W < MAX_SHIFT) begin : g_bad_rnd
      $error("fp8_narrow: RND_W too small for stochastic rounding");
   end

   logic             stall;
   unp_t             in_unp, s1_unp;
   logic             s1_v, s1_sat, s1_sto;
   fmt_e             s1_fmt, out_fmt;
   logic [RND_W-1:0] s1_rnd;
   logic [7:0]       cand_code [NUM_FMT];
   logic             cand_ovf  [NUM_FMT];
   logic             cand_unf  [NUM_FMT];

   assign stall    = out_valid & ~out_ready;
   assign in_ready = ~stall;

   fp8_narrow_unpack u_unpack (.f32(in_data), .unp(in_unp));

   // Stage 1: unpacked operand and per-transfer controls
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v   <= 1'b0;
         s1_unp <= '0;
         s1_fmt <= FMT_E4M3;
         s1_sat <= 1'b0;
         s1_sto <= 1'b0;
         s1_rnd <= '0;
      end else if (!stall) begin
         s1_v <= in_valid;
         if (in_valid) begin
            s1_unp <= in_unp;
            s1_fmt <= fmt_e'(in_fmt);
            s1_sat <= in_sat;
            s1_sto <= in_stoch;
            s1_rnd <= in_rand;
         end
      end
   end

   for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
      fp8_narrow_round #(
         .EXP_W   (fmt_exp_w(g)),
         .MAN_W   (fmt_man_w(g)),
         .IEEE_SP (g == 1),
         .STOCH_EN(STOCH_EN),
         .RND_W   (RND_W)
      ) u_round (
         .unp  (s1_unp),
         .sat  (s1_sat),
         .stoch(s1_sto),
         .rnd  (s1_rnd),
         .code (cand_code[g]),
         .ovf  (cand_ovf[g]),
         .unf  (cand_unf[g])
      );
   end

   // Stage 2: registered result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
         out_ovf   <= 1'b0;
         out_unf   <= 1'b0;
         out_fmt   <= FMT_E4M3;
      end else if (!stall) begin
         out_valid <= s1_v;
         if (s1_v) begin
            out_code <= cand_code[s1_fmt];
            out_ovf  <= cand_ovf[s1_fmt];
            out_unf  <= cand_unf[s1_fmt];
            out_fmt  <= s1_fmt;
         end
      end
   end

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_ovf) && $stable(out_unf)); // R2
   AST_E4M3_OVF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ovf && out_fmt == FMT_E4M3 |-> out_code[6:0] == 7'h7E); // R6
   AST_E5M2_OVF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ovf && out_fmt == FMT_E5M2 |-> out_code[6:0] == 7'h7B || out_code[6:0] == 7'h7C); // R7
   AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_unf |-> out_code[6:0] == 7'h00); // R5
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_ovf && out_unf)); // R12
endmodule

// File: tb/fp8_narrow_bench.sv
`timescale 1ns/1ps
module fp8_narrow_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_fmt = 1'b0, in_sat = 1'b0, in_stoch = 1'b0;
   logic [31:0] in_data = '0;
   logic [24:0] in_rand = '0;
   logic        out_ready = 1'b1;
   logic        in_ready, out_valid, out_ovf, out_unf;
   logic [7:0]  out_code;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   fp8_narrow u_fp8_narrow (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_fmt(in_fmt), .in_sat(in_sat), .in_stoch(in_stoch),
      .in_rand(in_rand), .out_valid(out_valid), .out_ready(out_ready),
      .out_code(out_code), .out_ovf(out_ovf), .out_unf(out_unf)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one transfer; result = {code, ovf, unf}
   task automatic xfer(input logic [31:0] d, input bit fmt, input bit sat, input bit sto,
                       input logic [24:0] r, input logic [7:0] ec, input bit eo, input bit eu,
                       input string req);
      @(negedge clk);
      in_data = d; in_fmt = fmt; in_sat = sat; in_stoch = sto; in_rand = r;
      in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b0, "R1 early", {15'd0, out_valid}, 16'd0);
      @(negedge clk);
      chk(out_valid == 1'b1, "R1 late", {15'd0, out_valid}, 16'd1);
      chk({out_code, out_ovf, out_unf} == {ec, eo, eu}, req,
          {6'd0, out_code, out_ovf, out_unf}, {6'd0, ec, eo, eu});
   endtask

   task automatic t_reset();
      chk(out_valid == 1'b0, "R1 reset valid", {15'd0, out_valid}, 16'd0);
      chk(in_ready == 1'b1, "R2 reset ready", {15'd0, in_ready}, 16'd1);
   endtask

   task automatic t_normals();
      xfer(32'h3F800000, 0, 0, 0, '0, 8'h38, 0, 0, "R3 1.0 fmt0");
      xfer(32'hC0200000, 0, 0, 0, '0, 8'hC2, 0, 0, "R3 -2.5 fmt0");
      xfer(32'h3F800000, 1, 0, 0, '0, 8'h3C, 0, 0, "R3 1.0 fmt1");
      xfer(32'h3C800000, 0, 0, 0, '0, 8'h08, 0, 0, "R3 min normal fmt0");
   endtask

   task automatic t_rne();
      xfer(32'h3F880000, 0, 0, 0, '0, 8'h38, 0, 0, "R4 tie even down");
      xfer(32'h3F980000, 0, 0, 0, '0, 8'h3A, 0, 0, "R4 tie odd up");
      xfer(32'h3FF80000, 0, 0, 0, '0, 8'h40, 0, 0, "R4 carry to exponent");
   endtask

   task automatic t_subnormal();
      xfer(32'h3B000000, 0, 0, 0, '0, 8'h01, 0, 0, "R5 min subnormal fmt0");
      xfer(32'h3BC00000, 0, 0, 0, '0, 8'h03, 0, 0, "R5 subnormal 3 fmt0");
      xfer(32'h3A800000, 0, 0, 0, '0, 8'h00, 0, 1, "R5 half tie to zero");
      xfer(32'h3AC00000, 0, 0, 0, '0, 8'h01, 0, 0, "R5 above half");
      xfer(32'h37800000, 1, 0, 0, '0, 8'h01, 0, 0, "R5 min subnormal fmt1");
      xfer(32'h37000000, 1, 0, 0, '0, 8'h00, 0, 1, "R5 below fmt1");
      xfer(32'h80000001, 0, 0, 0, '0, 8'h80, 0, 1, "R5 src subnormal");
   endtask

   task automatic t_ovf_fmt0();
      xfer(32'h43E00000, 0, 0, 0, '0, 8'h7E, 0, 0, "R6 448 exact");
      xfer(32'h43E80000, 0, 0, 0, '0, 8'h7E, 0, 0, "R6 464 tie");
      xfer(32'h43F00000, 0, 0, 0, '0, 8'h7E, 1, 0, "R6 480 sat ignored");
      xfer(32'hC9742400, 0, 1, 0, '0, 8'hFE, 1, 0, "R6 large negative");
   endtask

   task automatic t_ovf_fmt1();
      xfer(32'h47600000, 1, 0, 0, '0, 8'h7B, 0, 0, "R7 57344 exact");
      xfer(32'h47800000, 1, 0, 0, '0, 8'h7C, 1, 0, "R7 overflow to inf");
      xfer(32'h47800000, 1, 1, 0, '0, 8'h7B, 1, 0, "R7 overflow clamp");
      xfer(32'hC7700000, 1, 0, 0, '0, 8'hFC, 1, 0, "R7 tie rounds past max");
   endtask

   task automatic t_special();
      xfer(32'h7F800000, 1, 1, 0, '0, 8'h7C, 0, 0, "R8 inf fmt1 sat");
      xfer(32'hFF800000, 0, 0, 0, '0, 8'hFF, 0, 0, "R8 -inf fmt0");
      xfer(32'h7FC00000, 0, 0, 0, '0, 8'h7F, 0, 0, "R9 nan fmt0");
      xfer(32'hFFC00001, 1, 0, 0, '0, 8'hFE, 0, 0, "R9 -nan fmt1");
      xfer(32'h80000000, 0, 0, 0, '0, 8'h80, 0, 0, "R10 -0 fmt0");
      xfer(32'h00000000, 1, 0, 0, '0, 8'h00, 0, 0, "R10 +0 fmt1");
   endtask

   task automatic t_stoch();
      xfer(32'h3F880000, 0, 0, 1, 25'h007FFFF, 8'h38, 0, 0, "R11 no carry");
      xfer(32'h3F880000, 0, 0, 1, 25'h0080000, 8'h39, 0, 0, "R11 carry");
      xfer(32'h3F980000, 0, 0, 1, 25'h0000000, 8'h39, 0, 0, "R11 zero rand truncates");
      xfer(32'h3F800000, 0, 0, 1, 25'h1FFFFFF, 8'h38, 0, 0, "R11 exact unchanged");
      xfer(32'h3A800000, 0, 0, 1, 25'h07FFFFF, 8'h00, 0, 1, "R11 subnormal no carry");
      xfer(32'h3A800000, 0, 0, 1, 25'h0800000, 8'h01, 0, 0, "R11 subnormal carry");
   endtask

   task automatic t_backpressure();
      @(negedge clk);
      in_data = 32'h3F800000; in_fmt = 0; in_sat = 0; in_stoch = 0; in_valid = 1; out_ready = 0;
      @(negedge clk);
      in_data = 32'h40000000;
      @(negedge clk);
      chk(out_valid && out_code == 8'h38, "R2 first out", {8'd0, out_code}, 16'h0038);
      chk(in_ready == 1'b0, "R2 ready low", {15'd0, in_ready}, 16'd0);
      in_data = 32'hBF800000;
      @(negedge clk);
      chk(out_valid && out_code == 8'h38, "R2 held", {8'd0, out_code}, 16'h0038);
      out_ready = 1;
      @(negedge clk);
      in_valid = 0;
      chk(out_valid && out_code == 8'h40, "R2 second out", {8'd0, out_code}, 16'h0040);
      @(negedge clk);
      chk(out_valid && out_code == 8'hB8, "R2 third out", {8'd0, out_code}, 16'h00B8);
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 drained", {15'd0, out_valid}, 16'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_normals();
      t_rne();
      t_subnormal();
      t_ovf_fmt0();
      t_ovf_fmt1();
      t_special();
      t_stoch();
      t_backpressure();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule